// File: doc/BRIEF.md
# Oversampling Serial Byte Receiver

This block recovers bytes from an asynchronous serial line with no accompanying clock. The line idles high. Each frame opens with a low start bit, carries eight data bits with the least significant bit first, and closes with a high stop bit. A separate rate generator supplies a one-cycle enable, `os_tick`, eight times per bit period. The receiver samples the line only on those ticks, after the line has passed through a two-stage synchronizer.

A falling line is accepted as a start bit only after several consecutive low samples. Shorter low pulses are discarded as glitches. From the sample that confirms the start, every later bit is taken a fixed eight ticks after the one before it, which lands each sample near the middle of its bit.

Completed bytes collect in a shift register. On a valid stop bit they are copied into a holding register, and a full flag is raised. A host consumes a byte by pulsing `rd_data`, which clears the full flag. If a byte completes while the previous one is still unread, an overrun flag records the loss. The host clears that flag by pulsing `rd_status`.

Top module: `srx_os8_rx`

## Requirements
- R1: After reset, `rx_data` is 8'h00 and both `rx_full` and `rx_overrun` are 0.
- R2: A start bit is accepted only after four consecutive low line samples taken on `os_tick`. A low pulse that yields three or fewer low samples returns the receiver to idle, with no frame received and no flag changed.
- R3: After a start is confirmed, each data bit is sampled eight ticks after the previous sample. The first bit received becomes bit 0 of the byte.
- R4: When the stop sample (eight ticks after data bit 7) is high, the assembled byte is copied to `rx_data` and `rx_full` is set one clock later.
- R5: When the stop sample is low, the frame is dropped and `rx_data` and `rx_full` keep their values. The receiver then waits for the line to be high on a tick before it looks for another start, so the low tail of the bad stop bit does not open a false frame.
- R6: A one-clock pulse on `rd_data` clears `rx_full` and leaves `rx_data` unchanged. A byte load in the same cycle takes priority and keeps `rx_full` set.
- R7: A byte load while `rx_full` is 1 and `rd_data` is 0 sets `rx_overrun` and overwrites `rx_data` with the new byte.
- R8: A one-clock pulse on `rd_status` clears `rx_overrun` and leaves `rx_full` unchanged, unless an overrun occurs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Oversample enable, eight pulses per bit period |
| rxd | input | 1 | Asynchronous serial line, idle high |
| rd_data | input | 1 | Host read strobe for the received byte, clears the full flag |
| rd_status | input | 1 | Host read strobe for status, clears the overrun flag |
| rx_data | output | 8 | Holding register with the last received byte |
| rx_full | output | 1 | A byte is waiting to be read |
| rx_overrun | output | 1 | A byte arrived while the previous one was unread |

## Verification
The bench keeps the default parameters: eight data bits, eight ticks per bit, four low samples to qualify a start, and two synchronizer stages. It pulses `os_tick` every fourth clock, so one bit lasts 32 clocks.

Each sample then has several clocks of margin on both sides of a bit edge. This makes it possible to drive a 12-clock low pulse that yields exactly three low samples, one short of a start. A bad stop bit can also be driven whose low remainder is long enough to trigger a false start if the receiver went straight back to idle. Back-to-back frames without a read exercise overrun and the overwrite of the holding register.

// File: rtl/srx_pkg.sv
package srx_pkg;

    typedef enum logic [2:0] {
        SRX_IDLE,
        SRX_QUALIFY,
        SRX_BITS,
        SRX_STOP,
        SRX_WAIT_HIGH
    } srx_state_e;

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
    parameter int STAGES   = 2,
    parameter bit IDLE_LVL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] chain_d, chain_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                assign chain_d[g] = din;
            end else begin : g_next
                assign chain_d[g] = chain_q[g-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{IDLE_LVL}};
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/srx_frame_ctl.sv
module srx_frame_ctl
    import srx_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int OSR        = 8,
    parameter int START_LOWS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rx,
    output logic              frame_ld,
    output logic [DATA_W-1:0] frame_data
);

    localparam int CNT_W = (OSR > 1) ? $clog2(OSR) : 1;
    localparam int LOW_W = $clog2(START_LOWS + 1);
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OSR - 1);
    localparam logic [LOW_W-1:0] LOW_LAST = LOW_W'(START_LOWS - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

    typedef struct packed {
        srx_state_e        state;
        logic [CNT_W-1:0]  os_cnt;
        logic [LOW_W-1:0]  low_cnt;
        logic [IDX_W-1:0]  bit_idx;
        logic [DATA_W-1:0] shreg;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic ld_d;

    always_comb begin
        ctl_d = ctl_q;
        ld_d  = 1'b0;
        if (tick) begin
            case (ctl_q.state)
                SRX_IDLE: begin
                    if (!rx) begin
                        ctl_d.low_cnt = LOW_W'(1);
                        ctl_d.state   = SRX_QUALIFY;
                    end
                end
                SRX_QUALIFY: begin
                    if (rx) begin
                        ctl_d.state = SRX_IDLE;
                    end else if (ctl_q.low_cnt == LOW_LAST) begin
                        ctl_d.state   = SRX_BITS;
                        ctl_d.os_cnt  = '0;
                        ctl_d.bit_idx = '0;
                    end else begin
                        ctl_d.low_cnt = ctl_q.low_cnt + LOW_W'(1);
                    end
                end
                SRX_BITS: begin
                    if (ctl_q.os_cnt == CNT_LAST) begin
                        ctl_d.os_cnt = '0;
                        ctl_d.shreg  = {rx, ctl_q.shreg[DATA_W-1:1]};
                        if (ctl_q.bit_idx == IDX_LAST) begin
                            ctl_d.state = SRX_STOP;
                        end else begin
                            ctl_d.bit_idx = ctl_q.bit_idx + IDX_W'(1);
                        end
                    end else begin
                        ctl_d.os_cnt = ctl_q.os_cnt + CNT_W'(1);
                    end
                end
                SRX_STOP: begin
                    if (ctl_q.os_cnt == CNT_LAST) begin
                        ctl_d.os_cnt = '0;
                        if (rx) begin
                            ld_d        = 1'b1;
                            ctl_d.state = SRX_IDLE;
                        end else begin
                            ctl_d.state = SRX_WAIT_HIGH;
                        end
                    end else begin
                        ctl_d.os_cnt = ctl_q.os_cnt + CNT_W'(1);
                    end
                end
                SRX_WAIT_HIGH: begin
                    if (rx) ctl_d.state = SRX_IDLE;
                end
                default: ctl_d.state = SRX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.state   <= SRX_IDLE;
            ctl_q.os_cnt  <= '0;
            ctl_q.low_cnt <= '0;
            ctl_q.bit_idx <= '0;
            ctl_q.shreg   <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign frame_ld   = ld_d;
    assign frame_data = ctl_q.shreg;

endmodule

// File: rtl/srx_hold.sv
module srx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              rd_data,
    input  logic              rd_status,
    output logic [DATA_W-1:0] data,
    output logic              full,
    output logic              overrun
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              full;
        logic              ovr;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (rd_data)   hold_d.full = 1'b0;
        if (rd_status) hold_d.ovr  = 1'b0;
        if (ld) begin
            hold_d.data = ld_data;
            hold_d.full = 1'b1;
            if (hold_q.full && !rd_data) hold_d.ovr = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q.data <= '0;
            hold_q.full <= 1'b0;
            hold_q.ovr  <= 1'b0;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign data    = hold_q.data;
    assign full    = hold_q.full;
    assign overrun = hold_q.ovr;

endmodule

// File: rtl/srx_os8_rx.sv
module srx_os8_rx #(
    parameter int DATA_W      = 8,
    parameter int OSR         = 8,
    parameter int START_LOWS  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic              rxd,
    input  logic              rd_data,
    input  logic              rd_status,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_full,
    output logic              rx_overrun
);

    logic              rx_s;
    logic              frame_ld;
    logic [DATA_W-1:0] frame_data;

    srx_sync #(
        .STAGES   (SYNC_STAGES),
        .IDLE_LVL (1'b1)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rxd),
        .dout  (rx_s)
    );

    srx_frame_ctl #(
        .DATA_W     (DATA_W),
        .OSR        (OSR),
        .START_LOWS (START_LOWS)
    ) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (os_tick),
        .rx         (rx_s),
        .frame_ld   (frame_ld),
        .frame_data (frame_data)
    );

    srx_hold #(
        .DATA_W (DATA_W)
    ) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld        (frame_ld),
        .ld_data   (frame_data),
        .rd_data   (rd_data),
        .rd_status (rd_status),
        .data      (rx_data),
        .full      (rx_full),
        .overrun   (rx_overrun)
    );

endmodule

// File: rtl/srx_os8_rx_chk.sv
module srx_os8_rx_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ld,
    input logic              rd_data,
    input logic              rd_status,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_full,
    input logic              rx_overrun
);

    // R4
    load_sets_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> rx_full);

    // R5
    data_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> $stable(rx_data));

    // R6
    read_clears_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && !ld) |=> !rx_full);

    // R7
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld && rx_full && !rd_data) |=> rx_overrun);

    // R8
    status_clears_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_status && !(ld && rx_full && !rd_data)) |=> !rx_overrun);

    // R8
    status_keeps_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_status && !rd_data && !ld) |=> (rx_full == $past(rx_full)));

endmodule

bind srx_os8_rx srx_os8_rx_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ld         (frame_ld),
    .rd_data    (rd_data),
    .rd_status  (rd_status),
    .rx_data    (rx_data),
    .rx_full    (rx_full),
    .rx_overrun (rx_overrun)
);

// File: tb/srx_os8_rx_test.sv
module srx_os8_rx_test;

    localparam int TICK_DIV = 4;
    localparam int BIT_CLKS = 8 * TICK_DIV;
    localparam int NVEC     = 7;
    // fields: {stop bit, sent byte, expected full, expected data}
    localparam logic [17:0] VEC [NVEC] = '{
        {1'b1, 8'h55, 1'b1, 8'h55},
        {1'b1, 8'hA3, 1'b1, 8'hA3},
        {1'b0, 8'h7E, 1'b0, 8'hA3},
        {1'b1, 8'hC3, 1'b1, 8'hC3},
        {1'b1, 8'h00, 1'b1, 8'h00},
        {1'b1, 8'hFF, 1'b1, 8'hFF},
        {1'b1, 8'h81, 1'b1, 8'h81}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b0;
    logic       rxd = 1'b1;
    logic       rd_data = 1'b0;
    logic       rd_status = 1'b0;
    logic [7:0] rx_data;
    logic       rx_full;
    logic       rx_overrun;

    int n_checks = 0;
    int n_errors = 0;

    srx_os8_rx uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .os_tick    (os_tick),
        .rxd        (rxd),
        .rd_data    (rd_data),
        .rd_status  (rd_status),
        .rx_data    (rx_data),
        .rx_full    (rx_full),
        .rx_overrun (rx_overrun)
    );

    always #2 clk = ~clk;

    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            os_tick = (cnt == TICK_DIV - 1);
            cnt = (cnt == TICK_DIV - 1) ? 0 : cnt + 1;
        end
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_frame(input logic [7:0] b, input logic stop);
        rxd = 1'b0;
        repeat (BIT_CLKS) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            repeat (BIT_CLKS) @(negedge clk);
        end
        rxd = stop;
        repeat (BIT_CLKS) @(negedge clk);
        rxd = 1'b1;
        repeat (2 * BIT_CLKS) @(negedge clk);
    endtask

    task automatic pulse_rd_data();
        rd_data = 1'b1;
        @(negedge clk);
        rd_data = 1'b0;
    endtask

    task automatic pulse_rd_status();
        rd_status = 1'b1;
        @(negedge clk);
        rd_status = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        // R1 reset values
        check("R1 data", rx_data, 8'h00);
        check("R1 full", {7'd0, rx_full}, 8'd1 - 8'd1);
        check("R1 overrun", {7'd0, rx_overrun}, 8'h00);
        rst_n = 1'b1;
        repeat (40) @(negedge clk);

        // R3 R4 R5 R6 vector walk
        for (int v = 0; v < NVEC; v++) begin
            send_frame(VEC[v][16:9], VEC[v][17]);
            check(VEC[v][17] ? "R4 full" : "R5 full", {7'd0, rx_full}, {7'd0, VEC[v][8]});
            check(VEC[v][17] ? "R3 data" : "R5 data", rx_data, VEC[v][7:0]);
            if (rx_full) begin
                pulse_rd_data();
                check("R6 full cleared", {7'd0, rx_full}, 8'h00);
                check("R6 data kept", rx_data, VEC[v][7:0]);
            end
        end
        check("R7 no overrun after timely reads", {7'd0, rx_overrun}, 8'h00);

        // R2 glitch: 3 tick-periods low, at most three low samples
        rxd = 1'b0;
        repeat (3 * TICK_DIV) @(negedge clk);
        rxd = 1'b1;
        repeat (12 * BIT_CLKS) @(negedge clk);
        check("R2 glitch full", {7'd0, rx_full}, 8'h00);
        check("R2 glitch data", rx_data, 8'h81);
        send_frame(8'h96, 1'b1);
        check("R2 frame after glitch", rx_data, 8'h96);
        pulse_rd_data();

        // R7 overrun: two frames without reading
        send_frame(8'h11, 1'b1);
        send_frame(8'h22, 1'b1);
        check("R7 overrun set", {7'd0, rx_overrun}, 8'h01);
        check("R7 data overwritten", rx_data, 8'h22);
        check("R7 full", {7'd0, rx_full}, 8'h01);

        // R8 status read clears overrun only
        pulse_rd_status();
        check("R8 overrun cleared", {7'd0, rx_overrun}, 8'h00);
        check("R8 full kept", {7'd0, rx_full}, 8'h01);
        pulse_rd_data();
        check("R6 full cleared after overrun", {7'd0, rx_full}, 8'h00);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule